// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one machine cycle at a time on a processor-style external bus. The bus shares eight lines between the low address byte and the data byte. A separate set of lines carries the upper address byte. The requester hands over a cycle kind, a 16-bit address and a write byte. The controller then sequences the T-states, one per clock. It drives the address-latch strobe, the active-low read and write strobes, the memory/IO select and a two-bit cycle status. It also drives the output enables for both address groups and captures the byte returned on a read.

A slow device stretches the cycle by holding `ready` low. Another bus master can claim the bus with `hold`. The controller grants it with `hlda`, but only between machine cycles, never partway through one. A halt request parks the controller with its buses released. The next request wakes it.

Top module: `mux_bus_cycler`

## Requirements
- R1: Kind codes on `reqKind` are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 halt (6 and 7 also act as halt). From T1 to the last T-state, `{s1,s0}` is 11 for a fetch, 10 for reads, 01 for writes and 00 for halt. `ioM` is 1 for kinds 3 and 4 and 0 otherwise.
- R2: An accepted request starts T1 on the next clock. In T1 only, `ale` is 1, `adOe` is 1 and `adOut` carries address bits 7:0. `addrHi` carries address bits 15:8 with `addrHiOe` at 1 from T1 through the last T-state.
- R3: For read kinds (0, 1, 3), `rdN` is 0 from T2 through T3, wait states included. The byte on `adIn` at the end of T3 is presented on `rdData` while `done` is 1.
- R4: For write kinds (2, 4), `wrN` is 0 and `adOe` is 1 with `adOut` equal to the write byte from T2 through T3, wait states included. `rdN` stays 1.
- R5: A fetch lasts four T-states. Its T4 has `rdN`, `wrN` at 1 and `adOe` at 0. Reads and writes last three T-states. `done` is 1 for exactly one clock, on the last T-state.
- R6: `ready` is sampled at the end of T2 and of each wait state. Each low sample inserts one wait state, during which all strobes, enables and the address hold their values.
- R7: `hold` is acted on only while idle or halted. `hlda` rises one clock after `hold` is seen there. While `hlda` is 1, both enables are 0, `rdN` and `wrN` are 1, and no request is accepted. `hlda` falls one clock after `hold` drops. A `hold` raised during a cycle lets that cycle finish first.
- R8: A halt request releases both buses, asserts no strobe and gives no `done`. It drives status 00 and `ioM` 0. The halt lasts until the next request, and a hold taken during halt returns to halt.
- R9: After reset, and whenever idle: `ale` 0, `rdN`/`wrN` 1, both enables 0, `done` 0, `hlda` 0. `reqReady` is 1 exactly when idle or halted with `hold` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 3 | Cycle kind code (R1) |
| reqAddr | input | 16 | Cycle address |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | Request accepted this clock when valid |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| addrHi | output | 8 | Upper address byte |
| addrHiOe | output | 1 | Output enable for upper address |
| adOut | output | 8 | Shared-bus outgoing byte |
| adOe | output | 1 | Output enable for shared bus |
| adIn | input | 8 | Shared-bus incoming byte |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | 1 for I/O, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| done | output | 1 | Last T-state of a cycle |
| rdData | output | 8 | Captured read byte |

## Verification
The bound checker watches the invariants on every clock. `ale` lasts one clock and finds the shared bus driven with both strobes idle. Read and write strobes never overlap. An active write strobe always has the shared bus driven. `hlda` follows a sampled `hold` and keeps every enable and strobe released. `done` is a single-clock pulse. The checker cannot show the things that depend on the requested kind and the stimulus: the exact T-state count per kind, the status code, the wait-state count matching the low `ready` samples, the returned byte, the deferral of a mid-cycle hold, and the return to halt. The bench sweeps every kind against zero to two wait states to show these.

// File: rtl/busc_pkg.sv
package busc_pkg;
  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4,
    K_HALT  = 3'd5
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_HALT, ST_HOLD
  } tState_e;

  typedef struct packed {
    logic load;
    logic aleOn;
    logic rdOn;
    logic wrOn;
    logic loOe;
    logic hiOe;
    logic capture;
  } strb_t;

  function automatic logic isReadKind(input logic [2:0] k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic isWriteKind(input logic [2:0] k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction
endpackage

// File: rtl/busc_ctrl.sv
module busc_ctrl
  import busc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqKind,
  input  logic       ready,
  input  logic       hold,
  output logic       reqReady,
  output logic       hlda,
  output logic       done,
  output strb_t      strb
);
  tState_e state, stateNx;
  logic [2:0] kindQ;
  logic haltQ;
  logic parked, accept, readCyc, writeCyc, fetchCyc, strobeWin;

  assign parked   = (state == ST_IDLE) || (state == ST_HALT);
  assign reqReady = parked && !hold;
  assign accept   = reqReady && reqValid;
  assign readCyc  = isReadKind(kindQ);
  assign writeCyc = isWriteKind(kindQ);
  assign fetchCyc = (kindQ == K_FETCH);

  always_comb begin
    stateNx = state;
    unique case (state)
      ST_IDLE, ST_HALT: begin
        if (hold) stateNx = ST_HOLD;
        else if (reqValid) begin
          if (isReadKind(reqKind) || isWriteKind(reqKind)) stateNx = ST_T1;
          else stateNx = ST_HALT;
        end
      end
      ST_HOLD: if (!hold) stateNx = haltQ ? ST_HALT : ST_IDLE;
      ST_T1:   stateNx = ST_T2;
      ST_T2, ST_TW: stateNx = ready ? ST_T3 : ST_TW;
      ST_T3:   stateNx = fetchCyc ? ST_T4 : ST_IDLE;
      ST_T4:   stateNx = ST_IDLE;
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= K_HALT;
      haltQ <= 1'b0;
    end else begin
      state <= stateNx;
      if (accept) kindQ <= reqKind;
      if (stateNx == ST_HALT) haltQ <= 1'b1;
      else if (stateNx == ST_T1) haltQ <= 1'b0;
    end
  end

  assign strobeWin    = (state == ST_T2) || (state == ST_TW) || (state == ST_T3);
  assign strb.load    = accept;
  assign strb.aleOn   = (state == ST_T1);
  assign strb.rdOn    = strobeWin && readCyc;
  assign strb.wrOn    = strobeWin && writeCyc;
  assign strb.loOe    = (state == ST_T1) || (strobeWin && writeCyc);
  assign strb.hiOe    = (state == ST_T1) || strobeWin || (state == ST_T4);
  assign strb.capture = (state == ST_T3) && readCyc;
  assign hlda         = (state == ST_HOLD);
  assign done         = ((state == ST_T3) && !fetchCyc) || (state == ST_T4);
endmodule

// File: rtl/busc_dpath.sv
module busc_dpath
  import busc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strb_t                strb,
  input  logic [2:0]           reqKind,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                 addrHiOe,
  output logic [DATA_W-1:0]    adOut,
  output logic                 adOe,
  output logic                 ale,
  output logic                 rdN,
  output logic                 wrN,
  output logic                 ioM,
  output logic                 s1,
  output logic                 s0,
  output logic [DATA_W-1:0]    rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdQ, capQ;
  logic [1:0] statQ;
  logic ioQ;
  logic [1:0] statNx;

  always_comb begin
    unique case (reqKind)
      K_FETCH:         statNx = 2'b11;
      K_MRD, K_IORD:   statNx = 2'b10;
      K_MWR, K_IOWR:   statNx = 2'b01;
      default:         statNx = 2'b00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      wdQ   <= '0;
      capQ  <= '0;
      statQ <= 2'b00;
      ioQ   <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        wdQ   <= reqWdata;
        statQ <= statNx;
        ioQ   <= (reqKind == K_IORD) || (reqKind == K_IOWR);
      end
      if (strb.capture) capQ <= adIn;
    end
  end

  assign addrHi   = addrQ[ADDR_W-1:DATA_W];
  assign addrHiOe = strb.hiOe;
  assign adOut    = strb.aleOn ? addrQ[DATA_W-1:0] : wdQ;
  assign adOe     = strb.loOe;
  assign ale      = strb.aleOn;
  assign rdN      = !strb.rdOn;
  assign wrN      = !strb.wrOn;
  assign {s1, s0} = statQ;
  assign ioM      = ioQ;
  assign rdData   = strb.capture ? adIn : capQ;
endmodule

// File: rtl/mux_bus_cycler.sv
module mux_bus_cycler
  import busc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [2:0]               reqKind,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     reqReady,
  input  logic                     ready,
  input  logic                     hold,
  output logic                     hlda,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     addrHiOe,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     s1,
  output logic                     s0,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData
);
  strb_t strb;

  busc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .ready(ready), .hold(hold), .reqReady(reqReady), .hlda(hlda),
    .done(done), .strb(strb)
  );

  busc_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqKind(reqKind),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .adIn(adIn),
    .addrHi(addrHi), .addrHiOe(addrHiOe), .adOut(adOut), .adOe(adOe),
    .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM), .s1(s1), .s0(s0),
    .rdData(rdData)
  );
endmodule

// File: rtl/busc_chk.sv
module busc_chk (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic hold,
  input logic hlda,
  input logic addrHiOe,
  input logic adOe,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic done
);
  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  // R2
  ale_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (adOe && addrHiOe && rdN && wrN));
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdN || wrN));
  // R4
  wr_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe);
  // R7
  hlda_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (!adOe && !addrHiOe && rdN && wrN && !done && !reqReady));
  // R7
  hlda_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hlda) |-> $past(hold));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!hlda && rdN && wrN && !ale && !done));
endmodule

bind mux_bus_cycler busc_chk u_chk (.*);

// File: tb/mux_bus_cycler_tb.sv
`timescale 1ns/1ps
module mux_bus_cycler_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqKind = 3'd0;
  logic [15:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady;
  logic ready = 1'b1;
  logic hold = 1'b0;
  logic hlda;
  logic [7:0] addrHi;
  logic addrHiOe;
  logic [7:0] adOut;
  logic adOe;
  logic [7:0] adIn;
  logic ale, rdN, wrN, ioM, s1, s0, done;
  logic [7:0] rdData;
  logic [15:0] latA = '0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mux_bus_cycler u_dut (.*);

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (ale) latA <= {addrHi, adOut};
  assign adIn = rdN ? 8'hEE : memByte(latA);

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkBus(input string req, input logic eAle, input logic eRdN,
                        input logic eWrN, input logic eLoOe, input logic eHiOe,
                        input logic eDone);
    chk(ale == eAle, req, "ale", ale, eAle);
    chk(rdN == eRdN, req, "rdN", rdN, eRdN);
    chk(wrN == eWrN, req, "wrN", wrN, eWrN);
    chk(adOe == eLoOe, req, "adOe", adOe, eLoOe);
    chk(addrHiOe == eHiOe, req, "addrHiOe", addrHiOe, eHiOe);
    chk(done == eDone, req, "done", done, eDone);
  endtask

  task automatic chkStatus(input logic [2:0] k);
    logic [1:0] eS;
    logic eIo;
    case (k)
      3'd0: eS = 2'b11;
      3'd1, 3'd3: eS = 2'b10;
      3'd2, 3'd4: eS = 2'b01;
      default: eS = 2'b00;
    endcase
    eIo = (k == 3'd3) || (k == 3'd4);
    chk({s1, s0} == eS, "R1", "status", {s1, s0}, eS);
    chk(ioM == eIo, "R1", "ioM", ioM, eIo);
  endtask

  task automatic doCycle(input logic [2:0] k, input logic [15:0] a,
                         input logic [7:0] w, input int nw, input logic holdMid);
    logic isRd, isWr, isFetch;
    isRd = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    isWr = (k == 3'd2) || (k == 3'd4);
    isFetch = (k == 3'd0);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWdata = w; ready = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    // T1
    chkBus("R2", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk(adOut == a[7:0], "R2", "adOut low addr", adOut, a[7:0]);
    chk(addrHi == a[15:8], "R2", "addrHi", addrHi, a[15:8]);
    chkStatus(k);
    @(negedge clk);
    // T2
    chkBus(isWr ? "R4" : "R3", 1'b0, !isRd, !isWr, isWr, 1'b1, 1'b0);
    if (isWr) chk(adOut == w, "R4", "write byte", adOut, w);
    chk(addrHi == a[15:8], "R2", "addrHi T2", addrHi, a[15:8]);
    if (holdMid) hold = 1'b1;
    chk(hlda == 1'b0, "R7", "hlda mid cycle", hlda, 0);
    ready = (nw == 0);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      // wait state
      chkBus("R6", 1'b0, !isRd, !isWr, isWr, 1'b1, 1'b0);
      if (isWr) chk(adOut == w, "R6", "write byte in wait", adOut, w);
      chk(addrHi == a[15:8], "R6", "addrHi in wait", addrHi, a[15:8]);
      chkStatus(k);
      ready = (i == nw - 1);
    end
    @(negedge clk);
    // T3
    ready = 1'b1;
    chkBus(isWr ? "R4" : "R3", 1'b0, !isRd, !isWr, isWr, 1'b1, !isFetch);
    if (isWr) chk(adOut == w, "R4", "write byte T3", adOut, w);
    if (isRd && !isFetch)
      chk(rdData == memByte(a), "R3", "read byte", rdData, memByte(a));
    chkStatus(k);
    chk(hlda == 1'b0, "R7", "hlda in T3", hlda, 0);
    if (isFetch) begin
      @(negedge clk);
      // T4
      chkBus("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
      chk(rdData == memByte(a), "R3", "fetch byte", rdData, memByte(a));
      chkStatus(k);
    end
    @(negedge clk);
    // idle
    chkBus("R5", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(reqReady == !holdMid, "R9", "reqReady idle", reqReady, !holdMid);
    if (holdMid) begin
      chk(hlda == 1'b0, "R7", "hlda before sample", hlda, 0);
      @(negedge clk);
      chk(hlda == 1'b1, "R7", "hlda granted", hlda, 1);
      chkBus("R7", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      reqValid = 1'b1; reqKind = 3'd1; reqAddr = 16'hBEEF;
      @(negedge clk);
      chk(hlda == 1'b1 && ale == 1'b0, "R7", "request ignored in hold",
          {hlda, ale}, 2'b10);
      reqValid = 1'b0;
      hold = 1'b0;
      @(negedge clk);
      chk(hlda == 1'b0, "R7", "hlda release", hlda, 0);
      chk(reqReady == 1'b1, "R9", "reqReady after hold", reqReady, 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chkBus("R9", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(hlda == 1'b0, "R9", "hlda reset", hlda, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R9", "reqReady after reset", reqReady, 1);

    for (int k = 0; k < 5; k++)
      for (int nw = 0; nw < 3; nw++)
        for (int ai = 0; ai < 2; ai++) begin
          logic [15:0] a;
          a = 16'h1234 + 16'(k) * 16'h1111 + 16'(nw) * 16'h0101 + 16'(ai) * 16'h8080;
          doCycle(3'(k), a, a[7:0] ^ 8'hC3, nw, (nw == 1) && (ai == 1));
        end

    // R8 halt
    reqValid = 1'b1; reqKind = 3'd5;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chkBus("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      chkStatus(3'd5);
      chk(reqReady == 1'b1, "R8", "reqReady in halt", reqReady, 1);
      @(negedge clk);
    end
    hold = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(hlda == 1'b1, "R7", "hlda from halt", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    chk(hlda == 1'b0, "R8", "hlda off back to halt", hlda, 0);
    chkStatus(3'd5);
    chk(reqReady == 1'b1, "R8", "halt resumes", reqReady, 1);
    @(negedge clk);
    chkBus("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    // wake from halt with a memory read
    doCycle(3'd1, 16'hA5C3, 8'h00, 0, 1'b0);
    // halt kind 7 also halts
    reqValid = 1'b1; reqKind = 3'd7;
    @(negedge clk);
    reqValid = 1'b0;
    chkBus("R1", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chkStatus(3'd7);
    doCycle(3'd4, 16'h0FF0, 8'h99, 2, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule